// File: doc/BRIEF.md
# Regulator power-good sequencing controller

This block decides when the on-chip supply may be trusted and the device may leave reset. It runs a settling-delay counter of a fixed number of clock cycles. Two wake events can start it. At first power-up, the counter starts once the always-on low-power domain reports that it is powered. When the chip leaves a low-power mode, the counter starts when the high-power regulator's power-down request is withdrawn. If either condition becomes inactive, the counter goes back to zero. A full delay then runs again from the start.

When the counter reaches its terminal count, it raises an end-of-count flag. That flag is ANDed with a main-domain voltage-good input to form the regulator-ready output, and the reset controller uses this output to release the device reset. A small register port holds a mask bit for the 5 V low-voltage detector status, which is masked by default during power-up. The same port shows the gated status together with the sequencing state. The detector status is active-high for "supply above threshold". A detector that is powered down drives its output high, so it reads as healthy and never as a fault. Every asynchronous input passes through a two-flop synchronizer.

Top module: `vreg_ready_ctrl`

## Requirements
- R1: While rst_ni is low, eoc_o and vreg_ok_o are 0 and the mask bit is 1 (masked). The mask bit reads back as bit 0 of address 0.
- R2: Each of lp_dom_pwr_i, hp_pd_req_i, main_vok_i and lvd5_i takes effect through two synchronizer flops. eoc_o rises exactly DELAY+2 rising edges after the start condition becomes true at the pins, and not one edge earlier.
- R3: While lp_dom_pwr_i is low, the counter is held at zero and eoc_o stays 0.
- R4: While hp_pd_req_i is high, the counter is held at zero. When the request is withdrawn, a new delay starts from zero, even if an earlier count was only partly done.
- R5: After the terminal count is reached, eoc_o stays 1 while the start condition holds. The counter does not wrap.
- R6: If the start condition becomes false while eoc_o is 1, eoc_o and vreg_ok_o fall on the third rising edge after the pin change.
- R7: vreg_ok_o is 1 exactly when eoc_o is 1 and the synchronized main_vok_i is 1. A change on main_vok_i reaches vreg_ok_o two edges later.
- R8: lvd5_stat_o equals the synchronized lvd5_i AND NOT the mask bit. A high detector level (including a powered-down detector) is reported as 1, meaning healthy. A masked status reads 0.
- R9: Register map. Address 0 is control, and bit 0 is the mask (read/write). Address 1 is read-only status with bit 0 = lvd5_stat_o, bit 1 = eoc_o and bit 2 = vreg_ok_o. Writes to address 1 are ignored. Addresses 2 and 3 read 0. Upper data bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lp_dom_pwr_i | input | 1 | Always-on low-power domain powered (async) |
| hp_pd_req_i | input | 1 | High-power regulator power-down request (async) |
| main_vok_i | input | 1 | Main-domain voltage good (async) |
| lvd5_i | input | 1 | 5 V detector status, 1 = above threshold or powered down (async) |
| reg_addr_i | input | ADDR_W | Register address |
| reg_we_i | input | 1 | Register write enable |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data (same cycle) |
| eoc_o | output | 1 | Settling delay complete |
| vreg_ok_o | output | 1 | Regulator ready, releases device reset |
| lvd5_stat_o | output | 1 | Masked 5 V detector status |

## Verification
The bench builds the block with DELAY = 5, ADDR_W = 2 and DATA_W = 8. The short delay makes the terminal count reachable in a few cycles. The exact edge where eoc_o rises, the held terminal count and the restart after a partial count can therefore all be sampled on exact edges. A two-bit address covers every location, including the unused ones that must read zero.

// File: rtl/vreg_pkg.sv
package vreg_pkg;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned A_CTRL      = 0;
  localparam int unsigned A_STAT      = 1;
  localparam int unsigned B_MASK      = 0;
  localparam int unsigned B_LVD       = 0;
  localparam int unsigned B_EOC       = 1;
  localparam int unsigned B_OK        = 2;

  typedef struct packed {
    logic lp_pwr;
    logic pd_req;
    logic vok;
    logic lvd5;
  } async_in_t;

  // Count only while the always-on domain is up and no power-down is requested
  function automatic logic start_cond(async_in_t s);
    return s.lp_pwr & ~s.pd_req;
  endfunction
endpackage

// File: rtl/vreg_sync.sv
module vreg_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = vreg_pkg::SYNC_STAGES
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/vreg_dly_cnt.sv
module vreg_dly_cnt #(
  parameter int unsigned DELAY = 256,
  localparam int unsigned CNT_W = $clog2(DELAY + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic eoc_o
);
  localparam logic [CNT_W-1:0] TERM = CNT_W'(DELAY);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i)        cnt_q <= '0;
    else if (cnt_q != TERM) cnt_q <= cnt_q + 1'b1;
  end

  assign eoc_o = (cnt_q == TERM);
endmodule

// File: rtl/vreg_regs.sv
module vreg_regs #(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              lvd5_s_i,
  input  logic              eoc_i,
  input  logic              ok_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mask_o,
  output logic              lvd5_stat_o
);
  import vreg_pkg::*;

  logic mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   mask_q <= 1'b1;
    else if (we_i && addr_i == ADDR_W'(A_CTRL))    mask_q <= wdata_i[B_MASK];
  end

  assign mask_o      = mask_q;
  assign lvd5_stat_o = lvd5_s_i & ~mask_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(A_CTRL)) begin
      rdata_o[B_MASK] = mask_q;
    end else if (addr_i == ADDR_W'(A_STAT)) begin
      rdata_o[B_LVD] = lvd5_stat_o;
      rdata_o[B_EOC] = eoc_i;
      rdata_o[B_OK]  = ok_i;
    end
  end
endmodule

// File: rtl/vreg_ready_ctrl.sv
module vreg_ready_ctrl #(
  parameter int unsigned DELAY  = 256,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lp_dom_pwr_i,
  input  logic              hp_pd_req_i,
  input  logic              main_vok_i,
  input  logic              lvd5_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              eoc_o,
  output logic              vreg_ok_o,
  output logic              lvd5_stat_o
);
  import vreg_pkg::*;

  async_in_t raw, syn;
  logic      run, mask;

  assign raw = '{lp_pwr: lp_dom_pwr_i, pd_req: hp_pd_req_i,
                 vok: main_vok_i, lvd5: lvd5_i};

  vreg_sync #(.W($bits(async_in_t))) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  assign run = start_cond(syn);

  vreg_dly_cnt #(.DELAY(DELAY)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .eoc_o (eoc_o)
  );

  assign vreg_ok_o = eoc_o & syn.vok;

  vreg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (reg_addr_i),
    .we_i       (reg_we_i),
    .wdata_i    (reg_wdata_i),
    .lvd5_s_i   (syn.lvd5),
    .eoc_i      (eoc_o),
    .ok_i       (vreg_ok_o),
    .rdata_o    (reg_rdata_o),
    .mask_o     (mask),
    .lvd5_stat_o(lvd5_stat_o)
  );
endmodule

// File: rtl/vreg_ready_ctrl_chk.sv
module vreg_ready_ctrl_chk #(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              run,
  input logic              eoc,
  input logic              vok_s,
  input logic              ok,
  input logic              mask,
  input logic              lvd_s,
  input logic              lvd_stat,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata
);
  // R6
  clear_on_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> !eoc);

  // R5
  hold_terminal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoc && run) |=> eoc);

  // R4
  count_needs_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eoc) |-> $past(run));

  // R7
  ready_needs_vok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok |-> (vok_s && eoc));

  // R8
  masked_stat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvd_stat |-> (lvd_s && !mask));

  // R9
  mask_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we && addr == '0) |=> (mask == $past(wdata[0])));
endmodule

bind vreg_ready_ctrl vreg_ready_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .run     (run),
  .eoc     (eoc_o),
  .vok_s   (syn.vok),
  .ok      (vreg_ok_o),
  .mask    (mask),
  .lvd_s   (syn.lvd5),
  .lvd_stat(lvd5_stat_o),
  .we      (reg_we_i),
  .addr    (reg_addr_i),
  .wdata   (reg_wdata_i)
);

// File: tb/vreg_ready_ctrl_test.sv
module vreg_ready_ctrl_test;
  localparam int unsigned DELAY  = 5;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned NSTEP  = 18;

  // {lp, pd, vok, lvd, wait edges[7:0], exp eoc, exp ok, exp stat}
  localparam logic [14:0] TBL [NSTEP] = '{
    {4'b0011, 8'd10, 3'b000},  // R3 held while domain unpowered
    {4'b1011, 8'd6,  3'b000},  // R2 one edge short
    {4'b1011, 8'd1,  3'b110},  // R2 exact edge
    {4'b1011, 8'd20, 3'b110},  // R5 no wrap
    {4'b1001, 8'd2,  3'b100},  // R7 vok drop
    {4'b1011, 8'd2,  3'b110},  // R7 vok back
    {4'b1111, 8'd2,  3'b110},  // R6 not yet cleared
    {4'b1111, 8'd1,  3'b000},  // R6 cleared third edge
    {4'b1011, 8'd6,  3'b000},  // R4 restart, short
    {4'b1011, 8'd1,  3'b110},  // R4 restart, exact
    {4'b1111, 8'd3,  3'b000},  // R4 request again
    {4'b1011, 8'd3,  3'b000},  // R4 partial count
    {4'b1111, 8'd3,  3'b000},  // R4 abort partial
    {4'b1011, 8'd6,  3'b000},  // R4 full delay from zero
    {4'b1011, 8'd1,  3'b110},  // R4 done
    {4'b0011, 8'd2,  3'b110},  // R6 domain drop pending
    {4'b0011, 8'd1,  3'b000},  // R6 domain drop cleared
    {4'b0011, 8'd5,  3'b000}   // R3 stays clear
  };
  localparam string TAG [NSTEP] = '{"R3", "R2", "R2", "R5", "R7", "R7", "R6", "R6",
    "R4", "R4", "R4", "R4", "R4", "R4", "R4", "R6", "R6", "R3"};

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              lp_dom_pwr_i = 1'b0, hp_pd_req_i = 1'b0, main_vok_i = 1'b0, lvd5_i = 1'b0;
  logic [ADDR_W-1:0] reg_addr_i = '0;
  logic              reg_we_i = 1'b0;
  logic [DATA_W-1:0] reg_wdata_i = '0;
  logic [DATA_W-1:0] reg_rdata_o;
  logic              eoc_o, vreg_ok_o, lvd5_stat_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  vreg_ready_ctrl #(.DELAY(DELAY), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (.*);

  task automatic chk(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] exp, string tag);
    reg_addr_i = a;
    #1 chk(tag, reg_rdata_o, exp, $sformatf("read addr %0d", a));
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    main_vok_i = 1'b1; lvd5_i = 1'b1;
    wait_n(3);
    // R1 reset state
    chk("R1", {7'd0, eoc_o}, 8'd0, "eoc in reset");
    chk("R1", {7'd0, vreg_ok_o}, 8'd0, "ok in reset");
    rd(2'd0, 8'h01, "R1");
    rst_ni = 1'b1;
    wait_n(1);

    for (int i = 0; i < int'(NSTEP); i++) begin
      {lp_dom_pwr_i, hp_pd_req_i, main_vok_i, lvd5_i} = TBL[i][14:11];
      wait_n(int'(TBL[i][10:3]));
      chk(TAG[i], {7'd0, eoc_o},       {7'd0, TBL[i][2]}, $sformatf("eoc step %0d", i));
      chk(TAG[i], {7'd0, vreg_ok_o},   {7'd0, TBL[i][1]}, $sformatf("ok step %0d", i));
      chk(TAG[i], {7'd0, lvd5_stat_o}, {7'd0, TBL[i][0]}, $sformatf("stat step %0d", i));
    end

    // R8 unmask: healthy (or powered-down) detector reads 1
    wr(2'd0, 8'h00);
    chk("R8", {7'd0, lvd5_stat_o}, 8'd1, "unmasked high level");
    rd(2'd1, 8'h01, "R9");
    lvd5_i = 1'b0;
    wait_n(1);
    chk("R2", {7'd0, lvd5_stat_o}, 8'd1, "lvd one edge after drop");
    wait_n(1);
    chk("R8", {7'd0, lvd5_stat_o}, 8'd0, "unmasked low level");
    // R9 status is read-only, unused addresses read zero
    wr(2'd1, 8'hFF);
    rd(2'd0, 8'h00, "R9");
    rd(2'd1, 8'h00, "R9");
    rd(2'd2, 8'h00, "R9");
    rd(2'd3, 8'h00, "R9");
    // R8 masked again hides the level
    wr(2'd0, 8'hFF);
    rd(2'd0, 8'h01, "R9");
    lvd5_i = 1'b1;
    wait_n(3);
    chk("R8", {7'd0, lvd5_stat_o}, 8'd0, "masked high level");
    // R9 status bits with a finished count
    wr(2'd0, 8'h00);
    lp_dom_pwr_i = 1'b1;
    wait_n(DELAY + 2);
    rd(2'd1, 8'h07, "R9");
    // R1 asynchronous reset mid-operation restores the mask
    rst_ni = 1'b0;
    #1;
    chk("R1", {6'd0, eoc_o, vreg_ok_o}, 8'd0, "async reset outputs");
    rd(2'd0, 8'h01, "R1");
    wait_n(2);
    rst_ni = 1'b1;
    wait_n(DELAY + 1);
    chk("R2", {7'd0, eoc_o}, 8'd0, "recount after reset short");
    wait_n(1);
    chk("R2", {7'd0, eoc_o}, 8'd1, "recount after reset exact");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule